// File: doc/BRIEF.md
# Stereo Silence Detector

This block watches a stream of decoded stereo PCM frames and raises a status output once the audio has been digitally silent for a long, fixed stretch. Each frame arrives as a left sample, a right sample and a single-cycle strobe that marks one word-clock period. A frame counts as silent only when both samples are exactly zero. No tolerance band is applied around zero.

The block counts consecutive silent frames. When the count reaches the threshold (8192 frames by default), the status flag goes high. It stays high for as long as silent frames keep arriving. The first frame with any nonzero bit on either channel restarts the count and drops the flag on the following clock edge. A synchronous reset returns the block to the not-silent state. Typical uses are powering down an output stage or muting downstream logic when a source has stopped sending audio.

Top module: `stereo_silence_detect`

## Requirements
- R1: While `rst` is high at a clock edge, `silent_o` is 0 at the next sample point and the run count restarts from zero. A full threshold of silent frames is then needed before `silent_o` rises.
- R2: A frame is silent only when every bit of both `left_smp` and `right_smp` is 0. A frame where one channel is zero and the other has any bit set, even only the least or most significant bit, is not silent.
- R3: `silent_o` rises on the clock edge that accepts the THRESH-th consecutive silent frame (default 8192). After THRESH-1 such frames it is still 0.
- R4: A frame strobe carrying a non-silent frame clears `silent_o` on that same clock edge and restarts the run count. A fresh run of THRESH silent frames is then needed to raise `silent_o` again.
- R5: Cycles with `frame_vld` low have no effect, whatever the sample inputs hold. The run count neither advances nor restarts, and `silent_o` holds its value.
- R6: The run count saturates at the threshold, so `silent_o` stays 1 for any number of silent frames beyond THRESH.
- R7: `silent_o` is a register output. It changes only on a clock edge at which `frame_vld` or `rst` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_vld | input | 1 | One-cycle strobe marking one stereo frame per word-clock period |
| left_smp | input | SAMPLE_W (24) | Left channel PCM sample, two's complement |
| right_smp | input | SAMPLE_W (24) | Right channel PCM sample, two's complement |
| silent_o | output | 1 | High once THRESH consecutive all-zero frames have been seen |

## Verification
A corrupted run count shows at the port only as a wrong rise time of `silent_o`. It can be early or late by any number of frames, or it can fail to rise. The bench therefore compares the flag after every single frame and idle cycle across full threshold-length runs. That catches an off-by-one on the very edge it occurs. A stuck or missed restart shows up within one frame as a flag that stays high after a nonzero sample. It also shows up a threshold later as a rise that comes too early after a mid-run interruption. Idle cycles carrying junk data are placed in the middle of runs, so that a strobe-qualification fault shifts the rise point where it can be seen.

// File: rtl/silence_pkg.sv
package silence_pkg;

   // Channel indices within a packed frame
   localparam int CH_LEFT  = 0;
   localparam int CH_RIGHT = 1;
   localparam int NUM_CH   = 2;

   // Counter implementation variants
   typedef enum logic [0:0] {
      CTR_UP   = 1'b0,
      CTR_DOWN = 1'b1
   } ctr_style_e;

   // Per-frame decision handed from the classifier to the run counter
   typedef struct packed {
      logic step;   // silent frame accepted
      logic clear;  // non-silent frame accepted
   } run_ctl_t;

   // Width needed to hold values 0..max_val
   function automatic int count_width(input int max_val);
      int w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/silence_zero_cmp.sv
module silence_zero_cmp
   import silence_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int CHANNELS = NUM_CH
) (
   input  logic [CHANNELS-1:0][SAMPLE_W-1:0] smp,
   output logic                              all_zero
);

   logic [CHANNELS-1:0] ch_zero;

   generate
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("silence_zero_cmp: SAMPLE_W must be at least 1");
      end
      if (CHANNELS < 1) begin : g_bad_ch
         $error("silence_zero_cmp: CHANNELS must be at least 1");
      end
      for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
         // exact-zero test, no tolerance band
         assign ch_zero[g] = ~|smp[g];
      end
   endgenerate

   assign all_zero = &ch_zero;

endmodule

// File: rtl/silence_run_ctr.sv
module silence_run_ctr
   import silence_pkg::*;
#(
   parameter int         THRESH = 8192,
   parameter ctr_style_e STYLE  = CTR_UP,
   localparam int        CNT_W  = count_width(THRESH)
) (
   input  logic     clk,
   input  logic     rst,
   input  run_ctl_t ctl,
   output logic     reached_d
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

   generate
      if (THRESH < 1) begin : g_bad_thresh
         $error("silence_run_ctr: THRESH must be at least 1");
      end

      if (STYLE == CTR_UP) begin : g_up
         // counts silent frames from zero upward, holds at LIMIT
         logic [CNT_W-1:0] cnt_q, cnt_d;

         always_comb begin
            cnt_d = cnt_q;
            if (ctl.clear)
               cnt_d = '0;
            else if (ctl.step && (cnt_q != LIMIT))
               cnt_d = cnt_q + 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_d;
         end

         assign reached_d = (cnt_d == LIMIT);
      end else begin : g_down
         // counts remaining frames down to zero, holds at zero
         logic [CNT_W-1:0] rem_q, rem_d;

         always_comb begin
            rem_d = rem_q;
            if (ctl.clear)
               rem_d = LIMIT;
            else if (ctl.step && (rem_q != '0))
               rem_d = rem_q - 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) rem_q <= LIMIT;
            else     rem_q <= rem_d;
         end

         assign reached_d = (rem_d == '0);
      end
   endgenerate

endmodule

// File: rtl/silence_flag_reg.sv
module silence_flag_reg (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic load_val,
   output logic flag_q
);

   always_ff @(posedge clk) begin
      if (rst)       flag_q <= 1'b0;
      else if (load) flag_q <= load_val;
   end

endmodule

// File: rtl/stereo_silence_detect.sv
module stereo_silence_detect
   import silence_pkg::*;
#(
   parameter int         SAMPLE_W = 24,
   parameter int         THRESH   = 8192,
   parameter ctr_style_e STYLE    = CTR_UP
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                frame_vld,
   input  logic [SAMPLE_W-1:0] left_smp,
   input  logic [SAMPLE_W-1:0] right_smp,
   output logic                silent_o
);

   logic [NUM_CH-1:0][SAMPLE_W-1:0] frame_smp;
   logic                            frame_zero;
   run_ctl_t                        run_ctl;
   logic                            run_reached;

   assign frame_smp[CH_LEFT]  = left_smp;
   assign frame_smp[CH_RIGHT] = right_smp;

   silence_zero_cmp #(
      .SAMPLE_W (SAMPLE_W),
      .CHANNELS (NUM_CH)
   ) u_cmp (
      .smp      (frame_smp),
      .all_zero (frame_zero)
   );

   assign run_ctl.step  = frame_vld &  frame_zero;
   assign run_ctl.clear = frame_vld & ~frame_zero;

   silence_run_ctr #(
      .THRESH (THRESH),
      .STYLE  (STYLE)
   ) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .ctl       (run_ctl),
      .reached_d (run_reached)
   );

   silence_flag_reg u_flag (
      .clk      (clk),
      .rst      (rst),
      .load     (frame_vld),
      .load_val (run_reached),
      .flag_q   (silent_o)
   );

endmodule

// File: rtl/silence_detect_chk.sv
module silence_detect_chk #(
   parameter int SAMPLE_W = 24,
   parameter int THRESH   = 8192
) (
   input logic                clk,
   input logic                rst,
   input logic                frame_vld,
   input logic [SAMPLE_W-1:0] left_smp,
   input logic [SAMPLE_W-1:0] right_smp,
   input logic                silent_o
);

   localparam int RW = $clog2(THRESH + 1) + 1;

   logic          quiet;
   logic [RW-1:0] run_q;
   logic          seen_edge;

   assign quiet = (left_smp == '0) && (right_smp == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q     <= '0;
         seen_edge <= 1'b1;
      end else begin
         if (frame_vld) begin
            if (!quiet)                    run_q <= '0;
            else if (run_q != RW'(THRESH)) run_q <= run_q + 1'b1;
         end
      end
   end

   // R1
   reset_clears_chk: assert property (@(posedge clk) rst |=> !silent_o);

   // R4
   loud_frame_drops_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_vld && !quiet) |=> !silent_o);

   // R3
   rise_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(silent_o) |-> (run_q == RW'(THRESH)));

   // R5
   idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_edge && !frame_vld) |=> $stable(silent_o));

   // R6
   stays_high_chk: assert property (@(posedge clk) disable iff (rst)
      (silent_o && frame_vld && quiet) |=> silent_o);

   // R2
   one_side_loud_chk: assert property (@(posedge clk) disable iff (rst)
      (frame_vld && ((left_smp == '0) != (right_smp == '0))) |=> !silent_o);

endmodule

bind stereo_silence_detect silence_detect_chk #(
   .SAMPLE_W (SAMPLE_W),
   .THRESH   (THRESH)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .frame_vld (frame_vld),
   .left_smp  (left_smp),
   .right_smp (right_smp),
   .silent_o  (silent_o)
);

// File: tb/stereo_silence_detect_test.sv
module stereo_silence_detect_test;

   localparam int SW = 24;
   localparam int TH = 8192;

   typedef struct {
      bit    exp;
      string req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          frame_vld = 1'b0;
   logic [SW-1:0] left_smp = '0;
   logic [SW-1:0] right_smp = '0;
   logic          silent_o;

   item_t exp_q[$];
   int    checks = 0;
   int    errors = 0;
   int    m_cnt  = 0;
   bit    m_flag = 1'b0;
   bit    done   = 1'b0;

   always #4 clk = ~clk;

   stereo_silence_detect #(.SAMPLE_W(SW), .THRESH(TH)) uut (
      .clk       (clk),
      .rst       (rst),
      .frame_vld (frame_vld),
      .left_smp  (left_smp),
      .right_smp (right_smp),
      .silent_o  (silent_o)
   );

   // monitor: compares just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (silent_o !== it.exp) begin
               errors++;
               $display("FAIL %s: silent_o=%0b expected=%0b at %0t",
                        it.req, silent_o, it.exp, $time);
            end
         end
      end
   end

   task automatic do_reset(input int cycles);
      @(negedge clk);
      rst = 1'b1; frame_vld = 1'b0;
      for (int i = 0; i < cycles; i++) begin
         m_cnt = 0; m_flag = 1'b0;
         exp_q.push_back('{1'b0, "R1"});
         if (i != cycles - 1) @(negedge clk);
      end
      @(negedge clk);
      rst = 1'b0;
   endtask

   // one cycle of stimulus; expected flag from the requirements
   task automatic drive(input bit vld, input logic [SW-1:0] l,
                        input logic [SW-1:0] r, input string req);
      frame_vld = vld; left_smp = l; right_smp = r;
      if (vld) begin
         if (l == '0 && r == '0) begin
            if (m_cnt < TH) m_cnt++;
         end else begin
            m_cnt = 0;
         end
         m_flag = (m_cnt == TH);
      end
      exp_q.push_back('{m_flag, req});
      @(negedge clk);
      frame_vld = 1'b0;
   endtask

   task automatic quiet_run(input int n, input string req);
      for (int i = 0; i < n; i++) drive(1'b1, '0, '0, req);
   endtask

   initial begin
      do_reset(3);
      // R3: THRESH-1 frames leave flag low, the THRESH-th raises it
      quiet_run(TH - 1, "R3");
      drive(1'b1, '0, '0, "R3");
      // R6: saturation keeps the flag up
      quiet_run(300, "R6");
      // R5: idle cycles with junk data do not clear the flag
      for (int i = 0; i < 5; i++) drive(1'b0, 24'hABCDEF, 24'h000001, "R5");
      // R4: a single loud left sample drops the flag at once
      drive(1'b1, 24'h000001, '0, "R4");
      // R4: count restarted; R5: idle junk mid-run neither adds nor clears
      quiet_run(4000, "R4");
      for (int i = 0; i < 7; i++) drive(1'b0, 24'h800000, 24'h7FFFFF, "R5");
      for (int i = 0; i < 7; i++) drive(1'b0, '0, '0, "R5");
      quiet_run(TH - 4001, "R5");
      drive(1'b1, '0, '0, "R5");
      // R2: only right channel MSB set is not silent
      drive(1'b1, '0, 24'h800000, "R2");
      quiet_run(TH - 1, "R2");
      // R2: left zero, right LSB set breaks the run before the limit
      drive(1'b1, '0, 24'h000001, "R2");
      quiet_run(TH - 1, "R2");
      drive(1'b1, 24'h400000, '0, "R2");
      quiet_run(20, "R7");
      // R7: flag does not move on idle cycles
      for (int i = 0; i < 3; i++) drive(1'b0, 24'h123456, '0, "R7");
      // R1: reset mid-run restarts counting from zero
      quiet_run(5000, "R1");
      do_reset(2);
      quiet_run(TH - 1, "R1");
      drive(1'b1, '0, '0, "R1");
      // R1: reset while flag is high clears it
      do_reset(1);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule